// File: doc/BRIEF.md
# Phase-Agnostic Read Data Transfer

This block carries a wide chunk of read data out of a capture clock domain whose phase against the system clock is unknown and may be moved while the design runs. The move is done in two steps. First the chunk is retimed into a reference clock that has the same frequency and a fixed zero phase. From there it goes to a slower core clock that is derived from the same source and is edge-aligned with the reference.

Each crossing uses a toggle flag and a holding register, not a synchronizer on every data bit. In the read domain a flag inverts whenever a chunk is parked. The reference domain sees that flag through a two-flop synchronizer and one extra delay flop. This extra delay ensures that every data bit has settled before the reference register samples the bus, whatever the read clock phase is. The reference domain then raises a second toggle that the core domain watches. When the core domain has taken the chunk, an acknowledge travels back to the read domain, and only then is the holding register free again.

Top module: `rdx_transfer`

## Requirements
- R1: After reset, `core_valid` is 0 and `rd_overflow` is 0.
- R2: Each accepted chunk appears on `core_data` exactly once. It is marked by `core_valid` high for exactly one core clock cycle, and `core_data` keeps that value until the next chunk is delivered.
- R3: A chunk presented while the previous transfer is still outstanding is dropped, and `rd_overflow` goes to 1 on the next read clock edge. The chunk already in flight is still delivered unchanged.
- R4: Chunks come out of the core domain in the order they were accepted in the read domain.
- R5: A chunk presented at least 30 read clock cycles after the previous accepted chunk is always accepted. This holds for any phase of `rd_clk` relative to `ref_clk`, including after the phase has been moved while the block is idle.
- R6: An accepted chunk is delivered on `core_valid` within 16 reference clock cycles of being presented.
- R7: `rd_overflow` is sticky. Once set, it stays 1 until the read domain is reset, and that reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_clk | input | 1 | Read capture clock; same rate as `ref_clk`, arbitrary phase |
| rd_rst | input | 1 | Synchronous reset, read domain |
| rd_valid | input | 1 | Chunk present on `rd_data` this read cycle |
| rd_data | input | DATA_W | Captured read chunk |
| rd_overflow | output | 1 | Sticky flag: a chunk arrived while a transfer was outstanding |
| ref_clk | input | 1 | Zero-phase reference clock at the read rate |
| ref_rst | input | 1 | Synchronous reset, reference domain |
| core_clk | input | 1 | Core clock; an integer divide of `ref_clk`, edge-aligned with it |
| core_rst | input | 1 | Synchronous reset, core domain |
| core_valid | output | 1 | One-cycle pulse: a new chunk is on `core_data` |
| core_data | output | DATA_W | Delivered chunk |

## Verification
The overflow flag is a registered result of the read edge at which `rd_valid` was high. The bench drives on the falling read edge and reads the flag on the following falling edge, half a cycle after that register updates. The time a chunk takes to arrive depends on the phase, so the bench does not expect it on a fixed cycle. It records when each chunk was presented and checks that the chunk arrives within the 16-reference-cycle bound of R6. `core_valid` and `core_data` are sampled on every falling core edge, compared against a queue of accepted chunks, and checked against the previous sample for the single-cycle pulse. Sends are spaced either 30 read cycles apart or back to back. This keeps each send clearly on one side of the acceptance rule and away from the uncertain region between the two.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

  // A toggle handshake has work pending when the two flags differ.
  function automatic logic tog_pending(input logic sent, input logic seen);
    return sent ^ seen;
  endfunction

  // Synchronizer length seen by the reference domain for the read toggle:
  // metastability stages plus the settle delay that trails the data.
  function automatic int sync_len(input int meta_stages, input int settle);
    return meta_stages + settle;
  endfunction

endpackage

// File: rtl/rdx_bit_sync.sv
module rdx_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rdx_read_side.sv
module rdx_read_side #(
  parameter int DATA_W      = 128,
  parameter int META_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ack_tog,     // from reference domain, asynchronous
  output logic              send_tog,
  output logic [DATA_W-1:0] hold_data,
  output logic              busy,
  output logic              accept,
  output logic              drop,
  output logic              overflow
);
  import rdx_pkg::*;

  logic ack_sync;

  rdx_bit_sync #(.STAGES(META_STAGES)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_tog),
    .q   (ack_sync)
  );

  assign busy   = tog_pending(send_tog, ack_sync);
  assign accept = in_valid & ~busy;
  assign drop   = in_valid &  busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      send_tog <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (accept) send_tog <= ~send_tog;
      if (drop)   overflow <= 1'b1;
    end
  end

  // Data register carries no reset: it is qualified by the toggle.
  always_ff @(posedge clk) begin
    if (accept) hold_data <= in_data;
  end
endmodule

// File: rtl/rdx_ref_side.sv
module rdx_ref_side #(
  parameter int DATA_W      = 128,
  parameter int META_STAGES = 2,
  parameter int SETTLE      = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_tog,     // from read domain, asynchronous
  input  logic [DATA_W-1:0] src_data,    // stable while src_tog is pending
  input  logic              core_seen,   // from core domain, phase aligned
  output logic              fwd_tog,
  output logic [DATA_W-1:0] fwd_data,
  output logic              ack_tog,
  output logic              load
);
  import rdx_pkg::*;

  localparam int LEN = sync_len(META_STAGES, SETTLE);

  logic src_sync;
  logic seen;
  logic core_idle;

  rdx_bit_sync #(.STAGES(LEN)) u_src_sync (
    .clk (clk),
    .rst (rst),
    .d   (src_tog),
    .q   (src_sync)
  );

  assign core_idle = ~tog_pending(fwd_tog, core_seen);
  assign load      = tog_pending(src_sync, seen) & core_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen    <= 1'b0;
      fwd_tog <= 1'b0;
      ack_tog <= 1'b0;
    end else begin
      if (load) begin
        seen    <= src_sync;
        fwd_tog <= ~fwd_tog;
      end else if (core_idle) begin
        ack_tog <= seen;     // release the read side once core has the chunk
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) fwd_data <= src_data;
  end
endmodule

// File: rtl/rdx_core_side.sv
module rdx_core_side #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwd_tog,
  input  logic [DATA_W-1:0] fwd_data,
  output logic              seen,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              load
);
  import rdx_pkg::*;

  assign load = tog_pending(fwd_tog, seen);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= load;
      if (load) seen <= fwd_tog;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       out_data <= '0;
    else if (load) out_data <= fwd_data;
  end
endmodule

// File: rtl/rdx_transfer.sv
module rdx_transfer #(
  parameter int DATA_W      = 128,
  parameter int META_STAGES = 2,
  parameter int SETTLE      = 1
) (
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_overflow,
  input  logic              ref_clk,
  input  logic              ref_rst,
  input  logic              core_clk,
  input  logic              core_rst,
  output logic              core_valid,
  output logic [DATA_W-1:0] core_data
);
  // Named internal events, visible to the bound checker.
  logic              rd_tog;
  logic [DATA_W-1:0] rd_hold;
  logic              rd_busy;
  logic              rd_accept;
  logic              rd_drop;
  logic              ref_tog;
  logic [DATA_W-1:0] ref_data;
  logic              ref_ack;
  logic              ref_load;
  logic              core_seen;
  logic              core_load;

  rdx_read_side #(.DATA_W(DATA_W), .META_STAGES(META_STAGES)) u_read (
    .clk       (rd_clk),
    .rst       (rd_rst),
    .in_valid  (rd_valid),
    .in_data   (rd_data),
    .ack_tog   (ref_ack),
    .send_tog  (rd_tog),
    .hold_data (rd_hold),
    .busy      (rd_busy),
    .accept    (rd_accept),
    .drop      (rd_drop),
    .overflow  (rd_overflow)
  );

  rdx_ref_side #(.DATA_W(DATA_W), .META_STAGES(META_STAGES), .SETTLE(SETTLE)) u_ref (
    .clk       (ref_clk),
    .rst       (ref_rst),
    .src_tog   (rd_tog),
    .src_data  (rd_hold),
    .core_seen (core_seen),
    .fwd_tog   (ref_tog),
    .fwd_data  (ref_data),
    .ack_tog   (ref_ack),
    .load      (ref_load)
  );

  rdx_core_side #(.DATA_W(DATA_W)) u_core (
    .clk       (core_clk),
    .rst       (core_rst),
    .fwd_tog   (ref_tog),
    .fwd_data  (ref_data),
    .seen      (core_seen),
    .out_valid (core_valid),
    .out_data  (core_data),
    .load      (core_load)
  );
endmodule

// File: rtl/rdx_transfer_checks.sv
module rdx_transfer_checks #(
  parameter int DATA_W = 128
) (
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              ref_clk,
  input logic              ref_rst,
  input logic              core_clk,
  input logic              core_rst,
  input logic              rd_busy,
  input logic              rd_drop,
  input logic              rd_overflow,
  input logic [DATA_W-1:0] rd_hold,
  input logic              ref_load,
  input logic              core_valid,
  input logic [DATA_W-1:0] core_data
);
  // R3: a dropped chunk raises the flag on the next read edge
  p_drop_flags_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_drop |=> rd_overflow);

  // R3: the parked chunk is left alone while its transfer is outstanding
  p_hold_stable_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_busy |=> $stable(rd_hold));

  // R7: overflow stays set until the read reset
  p_overflow_sticky_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_overflow |=> rd_overflow);

  // R2: the delivery pulse lasts one core cycle
  p_single_pulse_r2: assert property (@(posedge core_clk) disable iff (core_rst)
    core_valid |=> !core_valid);

  // R2: delivered data holds after its pulse
  p_data_holds_r2: assert property (@(posedge core_clk) disable iff (core_rst)
    core_valid |=> $stable(core_data));

  // R4: one reference load per read toggle, never two in a row
  p_ref_load_once_r4: assert property (@(posedge ref_clk) disable iff (ref_rst)
    ref_load |=> !ref_load);
endmodule

bind rdx_transfer rdx_transfer_checks #(.DATA_W(DATA_W)) u_checks (
  .rd_clk      (rd_clk),
  .rd_rst      (rd_rst),
  .ref_clk     (ref_clk),
  .ref_rst     (ref_rst),
  .core_clk    (core_clk),
  .core_rst    (core_rst),
  .rd_busy     (rd_busy),
  .rd_drop     (rd_drop),
  .rd_overflow (rd_overflow),
  .rd_hold     (rd_hold),
  .ref_load    (ref_load),
  .core_valid  (core_valid),
  .core_data   (core_data)
);

// File: tb/rdx_transfer_tb.sv
`timescale 1ns/1ps
module rdx_transfer_tb;
  localparam int W = 128;

  logic         rd_clk = 1'b0, ref_clk = 1'b0, core_clk = 1'b0;
  logic         rd_rst = 1'b1, ref_rst = 1'b1, core_rst = 1'b1;
  logic         rd_valid = 1'b0;
  logic [W-1:0] rd_data = '0;
  logic         rd_overflow, core_valid;
  logic [W-1:0] core_data;

  int  checks = 0, fails = 0;
  bit  finished = 0;
  real rd_shift = 3.0;   // pending phase move of the read clock, ns

  logic [W-1:0] exp_q[$];
  realtime      exp_t[$];
  logic         prev_valid = 1'b0;

  rdx_transfer #(.DATA_W(W)) u_dut (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_overflow(rd_overflow), .ref_clk(ref_clk), .ref_rst(ref_rst),
    .core_clk(core_clk), .core_rst(core_rst), .core_valid(core_valid),
    .core_data(core_data)
  );

  // 100 MHz reference, aligned core clock at half rate, read clock at the
  // reference rate with a phase that the bench can move.
  always #5  ref_clk  = ~ref_clk;
  always #10 core_clk = ~core_clk;
  initial forever begin
    if (rd_shift != 0.0) begin
      #(rd_shift);
      rd_shift = 0.0;
    end
    #5 rd_clk = ~rd_clk;
  end

  task automatic check(input bit ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int k);
    return {32'hA5000000 + k, ~(32'h00010000 * k), 32'h3C3C0000 ^ k, 32'h0F0F0F0F * k};
  endfunction

  // Output monitor: compare each delivery with the accepted-chunk queue.
  always @(negedge core_clk) begin
    if (!core_rst && !finished) begin
      if (core_valid) begin
        if (prev_valid) check(1'b0, "R2 pulse longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected delivery", core_data, '0);
        end else begin
          logic [W-1:0] e;
          realtime      t;
          e = exp_q.pop_front();
          t = exp_t.pop_front();
          check(core_data === e, "R4 data and order", core_data, e);
          check(($realtime - t) <= 160.0, "R6 latency within 16 ref cycles",
                W'(int'($realtime - t)), W'(160));
        end
      end
      prev_valid = core_valid;
    end else begin
      prev_valid = 1'b0;
    end
  end

  task automatic send(input logic [W-1:0] d, input bit expect_accept);
    @(negedge rd_clk);
    rd_valid = 1'b1;
    rd_data  = d;
    if (expect_accept) begin
      exp_q.push_back(d);
      exp_t.push_back($realtime);
    end
    @(negedge rd_clk);
    rd_valid = 1'b0;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic drain;
    int guard = 0;
    while (exp_q.size() != 0 && guard < 200) begin
      @(negedge core_clk);
      guard++;
    end
    check(exp_q.size() == 0, "R5 all accepted chunks delivered",
          W'(exp_q.size()), '0);
    gap(30);
  endtask

  task automatic reset_all;
    @(negedge core_clk);
    rd_rst = 1'b1; ref_rst = 1'b1; core_rst = 1'b1;
    repeat (4) @(negedge core_clk);
    rd_rst = 1'b0; ref_rst = 1'b0; core_rst = 1'b0;
  endtask

  task automatic finish_run;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge ref_clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int k = 0;
    repeat (6) @(negedge core_clk);
    rd_rst = 1'b0; ref_rst = 1'b0; core_rst = 1'b0;
    @(negedge core_clk);
    check(core_valid == 1'b0, "R1 core_valid after reset", W'(core_valid), '0);
    check(rd_overflow == 1'b0, "R1 rd_overflow after reset", W'(rd_overflow), '0);

    // R5: spaced chunks under three different read phases
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 4; i++) begin
        send(pattern(k), 1'b1);
        k++;
        gap(30);
      end
      drain();
      check(rd_overflow == 1'b0, "R5 no overflow with spaced chunks", W'(rd_overflow), '0);
      rd_shift = (ph == 0) ? 2.7 : 4.1;   // move the read phase while idle
      gap(8);
    end

    // R3: back-to-back chunk is dropped, first one still arrives
    send(pattern(100), 1'b1);
    send(pattern(101), 1'b0);
    check(rd_overflow == 1'b1, "R3 overflow raised on drop", W'(rd_overflow), W'(1));
    drain();

    // R7: flag stays set, then a reset clears it
    gap(40);
    check(rd_overflow == 1'b1, "R7 overflow sticky", W'(rd_overflow), W'(1));
    reset_all();
    @(negedge rd_clk);
    check(rd_overflow == 1'b0, "R7 overflow cleared by reset", W'(rd_overflow), '0);
    check(core_valid == 1'b0, "R1 core_valid after second reset", W'(core_valid), '0);

    // R5: transfers resume after reset
    for (int i = 0; i < 3; i++) begin
      send(pattern(200 + i), 1'b1);
      gap(30);
    end
    drain();
    finish_run();
  end
endmodule